// File: doc/BRIEF.md
# Per-CPU Power State Controller

This block sequences the power state of one processor in a cluster. It has four resting states: running, a light standby entered when the core executes a wait instruction, a dormant state in which the logic is unpowered and the RAMs sit at retention voltage, and a fully off state. A sleeping core can leave standby on an interrupt or an event. Standby keeps the core in the coherence domain, so snoop traffic can still wake the L1 clock for a short time.

Software asks for a deep state with a dormant request or an unplug request. The request waits until the external cache-clean flag confirms that all dirty lines have been written back. After that flag is seen, the controller isolates the core from the coherence domain. Power is removed the next time the core asks for standby. Only an external wake event brings the core back. Power returns first, then reset is held for a fixed number of cycles, and then the clock runs again and isolation is dropped. The core with index 0 cannot be unplugged, so the controller for that core never acts on a deep request.

Top module: `cpu_pwr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, the outputs show the running state: `core_clk_en`=1, `l1_clk_en`=1, `iso_req`=0, `logic_pwr_en`=1, `ram_ret_en`=0, `ram_pwr_en`=1, `cpu_rst`=0.
- R2: When running with no deep request armed, `stby_req` at a clock edge moves the core to standby. From the next cycle both clock enables are 0. Power stays on and `iso_req` stays 0. A further `stby_req` while in standby has no effect.
- R3: In standby, `irq_wake` or `evt_wake` sampled at edge k gives `l1_clk_en`=1 after edge k and `core_clk_en`=1 after edge k+1. The core clock is therefore back exactly two cycles after the wake.
- R4: In standby without a wake, `l1_clk_en` follows `snoop_req` one cycle later and `core_clk_en` stays 0.
- R5: A pulse on `dorm_req` or `unplug_req` is held pending. While `clean_done` has not been seen, `iso_req` stays 0 and `stby_req` gives plain standby.
- R6: Once a request is pending, `clean_done` high at an edge arms it. `iso_req` is 1 from the next cycle, while the core still runs.
- R7: With a dormant request armed, the next `stby_req` gives `logic_pwr_en`=0, `ram_ret_en`=1, `ram_pwr_en`=0, `iso_req`=1 and both clocks off on the next cycle.
- R8: An unplug request, even if it comes together with a dormant request, makes that entry go to the off state instead: `logic_pwr_en`=0, `ram_ret_en`=0, `ram_pwr_en`=0, `iso_req`=1.
- R9: In the dormant and off states, `irq_wake`, `evt_wake`, `stby_req` and `snoop_req` have no effect on any output.
- R10: In the dormant or off state, `ext_wake` at edge w restores `logic_pwr_en` and `ram_pwr_en` after that edge and clears `ram_ret_en`. `cpu_rst` is then high for exactly `RST_HOLD` cycles with both clocks off and `iso_req` high. After that the core runs with `iso_req`=0 and the old request cleared, so a later `stby_req` gives plain standby.
- R11: With `CPU_ID`=0, deep requests are ignored: `iso_req` stays 0, and `logic_pwr_en` and `ram_pwr_en` stay 1.
- R12: `ext_wake` has no effect while the core is running or in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_req | input | 1 | Core executed a wait instruction |
| irq_wake | input | 1 | Interrupt pending (external, timer or watchdog) |
| evt_wake | input | 1 | Event signal from another core |
| snoop_req | input | 1 | Coherence request aimed at this core's L1 |
| dorm_req | input | 1 | Software request for the dormant state (pulse) |
| unplug_req | input | 1 | Hot-unplug request for the off state (pulse) |
| clean_done | input | 1 | Dirty lines have been written back |
| ext_wake | input | 1 | Wake event from the external power controller |
| core_clk_en | output | 1 | Core clock enable |
| l1_clk_en | output | 1 | L1 memory system clock enable |
| iso_req | output | 1 | Isolate the core from the coherence domain |
| logic_pwr_en | output | 1 | Core logic power switch |
| ram_ret_en | output | 1 | RAMs held at retention voltage |
| ram_pwr_en | output | 1 | RAMs at full supply |
| cpu_rst | output | 1 | Reset to the core |

## Verification
The bench builds two copies of the block. The first uses `CPU_ID`=1 and `RST_HOLD`=4, so a full dormant round trip and a full off round trip, with their reset-hold windows, fit in a few dozen cycles and the exact length of the reset pulse can be counted. The second uses `CPU_ID`=0 and receives the same stimulus. This puts the protected-core case next to the normal one, and the protected core's power and isolation outputs are checked on every cycle.

// File: rtl/cpu_pwr_pkg.sv
package cpu_pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN  = 3'd0,
    PS_STBY = 3'd1,
    PS_EXIT = 3'd2,
    PS_DORM = 3'd3,
    PS_OFF  = 3'd4,
    PS_RSTH = 3'd5
  } pwr_state_e;

  typedef struct packed {
    logic core_clk;
    logic l1_clk;
    logic iso;
    logic logic_pwr;
    logic ram_ret;
    logic ram_pwr;
    logic cpu_rst;
  } pwr_out_t;

  localparam pwr_out_t PWR_OUT_RESET = '{
    core_clk: 1'b1, l1_clk: 1'b1, iso: 1'b0, logic_pwr: 1'b1,
    ram_ret: 1'b0, ram_pwr: 1'b1, cpu_rst: 1'b0
  };

endpackage

// File: rtl/cpu_pwr_shut_track.sv
module cpu_pwr_shut_track #(
  parameter int CPU_ID = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic dorm_req,
  input  logic unplug_req,
  input  logic clean_done,
  input  logic clr,
  output logic armed_q,
  output logic arm_nxt,
  output logic deep_q
);

  // Core 0 may never be taken down; its requests are masked here.
  localparam logic ALLOW = (CPU_ID != 0);

  logic pend_q, pend_d, deep_d;

  always_comb begin
    pend_d  = pend_q | (ALLOW & (dorm_req | unplug_req));
    deep_d  = deep_q | (ALLOW & unplug_req);
    arm_nxt = armed_q | (pend_q & clean_done);
    if (clr) begin
      pend_d  = 1'b0;
      deep_d  = 1'b0;
      arm_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      deep_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      deep_q  <= deep_d;
      armed_q <= arm_nxt;
    end
  end

  // A pending request without a clean flag must not arm.
  assert_hold_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clean_done && !armed_q) |=> !armed_q);

endmodule

// File: rtl/cpu_pwr_rst_hold.sv
module cpu_pwr_rst_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/cpu_pwr_ctrl.sv
module cpu_pwr_ctrl
  import cpu_pwr_pkg::*;
#(
  parameter int CPU_ID   = 1,
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_req,
  input  logic irq_wake,
  input  logic evt_wake,
  input  logic snoop_req,
  input  logic dorm_req,
  input  logic unplug_req,
  input  logic clean_done,
  input  logic ext_wake,
  output logic core_clk_en,
  output logic l1_clk_en,
  output logic iso_req,
  output logic logic_pwr_en,
  output logic ram_ret_en,
  output logic ram_pwr_en,
  output logic cpu_rst
);

  pwr_state_e state_q, state_d;
  pwr_out_t   out_q, out_d;
  logic armed_q, arm_nxt, deep_q, hold_done, hold_start, req_clr;
  logic wake_any, deep_nxt;

  assign wake_any = irq_wake | evt_wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:  if (stby_req) state_d = armed_q ? (deep_q ? PS_OFF : PS_DORM) : PS_STBY;
      PS_STBY: if (wake_any) state_d = PS_EXIT;
      PS_EXIT: state_d = PS_RUN;
      PS_DORM,
      PS_OFF:  if (ext_wake) state_d = PS_RSTH;
      PS_RSTH: if (hold_done) state_d = PS_RUN;
      default: state_d = PS_RUN;
    endcase
  end

  assign deep_nxt   = (state_d == PS_DORM) || (state_d == PS_OFF);
  assign hold_start = (state_d == PS_RSTH) && (state_q != PS_RSTH);
  assign req_clr    = (state_q == PS_RUN) && deep_nxt;

  cpu_pwr_shut_track #(.CPU_ID(CPU_ID)) u_track (
    .clk(clk), .rst(rst), .dorm_req(dorm_req), .unplug_req(unplug_req),
    .clean_done(clean_done), .clr(req_clr),
    .armed_q(armed_q), .arm_nxt(arm_nxt), .deep_q(deep_q)
  );

  cpu_pwr_rst_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst(rst), .start(hold_start), .done(hold_done)
  );

  // Outputs decoded from the next state and registered with it.
  always_comb begin
    out_d.core_clk  = (state_d == PS_RUN);
    out_d.l1_clk    = (state_d == PS_RUN) || (state_d == PS_EXIT) ||
                      ((state_d == PS_STBY) && snoop_req);
    out_d.iso       = arm_nxt || deep_nxt || (state_d == PS_RSTH);
    out_d.logic_pwr = !deep_nxt;
    out_d.ram_ret   = (state_d == PS_DORM);
    out_d.ram_pwr   = !deep_nxt;
    out_d.cpu_rst   = (state_d == PS_RSTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_RUN;
      out_q   <= PWR_OUT_RESET;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  assign core_clk_en  = out_q.core_clk;
  assign l1_clk_en    = out_q.l1_clk;
  assign iso_req      = out_q.iso;
  assign logic_pwr_en = out_q.logic_pwr;
  assign ram_ret_en   = out_q.ram_ret;
  assign ram_pwr_en   = out_q.ram_pwr;
  assign cpu_rst      = out_q.cpu_rst;

  assert_stby_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RUN && stby_req && !armed_q) |=> (!core_clk_en && ram_pwr_en && !iso_req));

  assert_stby_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_STBY && wake_any) |=> (!core_clk_en && l1_clk_en) ##1 core_clk_en);

  assert_snoop_l1_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_STBY && !wake_any) |=> (l1_clk_en == $past(snoop_req) && !core_clk_en));

  assert_deep_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == PS_DORM || state_q == PS_OFF) && !ext_wake) |=> ($stable(logic_pwr_en) && $stable(ram_ret_en) && !core_clk_en));

  assert_wake_power_R10: assert property (@(posedge clk) disable iff (rst)
    ((state_q == PS_DORM || state_q == PS_OFF) && ext_wake) |=> (cpu_rst && logic_pwr_en && ram_pwr_en && !core_clk_en));

  assert_ext_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RUN && !stby_req && ext_wake) |=> (core_clk_en && !cpu_rst));

  generate
    if (CPU_ID == 0) begin : g_boot_core
      assert_cpu0_powered_R11: assert property (@(posedge clk) disable iff (rst)
        (logic_pwr_en && ram_pwr_en && !iso_req));
    end
  endgenerate

endmodule

// File: tb/test_cpu_pwr_ctrl.sv
module test_cpu_pwr_ctrl;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_req = 0, irq_wake = 0, evt_wake = 0, snoop_req = 0;
  logic dorm_req = 0, unplug_req = 0, clean_done = 0, ext_wake = 0;
  logic core_clk_en, l1_clk_en, iso_req, logic_pwr_en, ram_ret_en, ram_pwr_en, cpu_rst;
  logic c0_core, c0_l1, c0_iso, c0_logic, c0_ret, c0_pwr, c0_rst;

  always #4 clk = ~clk;

  cpu_pwr_ctrl #(.CPU_ID(1), .RST_HOLD(HOLD)) i_cpu_pwr_ctrl (
    .clk(clk), .rst(rst), .stby_req(stby_req), .irq_wake(irq_wake), .evt_wake(evt_wake),
    .snoop_req(snoop_req), .dorm_req(dorm_req), .unplug_req(unplug_req),
    .clean_done(clean_done), .ext_wake(ext_wake),
    .core_clk_en(core_clk_en), .l1_clk_en(l1_clk_en), .iso_req(iso_req),
    .logic_pwr_en(logic_pwr_en), .ram_ret_en(ram_ret_en), .ram_pwr_en(ram_pwr_en),
    .cpu_rst(cpu_rst)
  );

  cpu_pwr_ctrl #(.CPU_ID(0), .RST_HOLD(HOLD)) i_cpu_pwr_ctrl_c0 (
    .clk(clk), .rst(rst), .stby_req(stby_req), .irq_wake(irq_wake), .evt_wake(evt_wake),
    .snoop_req(snoop_req), .dorm_req(dorm_req), .unplug_req(unplug_req),
    .clean_done(clean_done), .ext_wake(ext_wake),
    .core_clk_en(c0_core), .l1_clk_en(c0_l1), .iso_req(c0_iso),
    .logic_pwr_en(c0_logic), .ram_ret_en(c0_ret), .ram_pwr_en(c0_pwr),
    .cpu_rst(c0_rst)
  );

  // Vector order: core_clk, l1_clk, iso, logic_pwr, ram_ret, ram_pwr, cpu_rst
  localparam logic [6:0] V_RUN  = 7'b1101010;
  localparam logic [6:0] V_ARM  = 7'b1111010;
  localparam logic [6:0] V_STBY = 7'b0001010;
  localparam logic [6:0] V_SNP  = 7'b0101010;
  localparam logic [6:0] V_EXIT = 7'b0101010;
  localparam logic [6:0] V_DORM = 7'b0010100;
  localparam logic [6:0] V_OFF  = 7'b0010000;
  localparam logic [6:0] V_RSTH = 7'b0011011;

  typedef struct {
    int         cyc;
    logic [6:0] v;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int ncyc = 0;
  int nchk = 0;
  int nfail = 0;
  logic [6:0] obs;

  assign obs = {core_clk_en, l1_clk_en, iso_req, logic_pwr_en, ram_ret_en, ram_pwr_en, cpu_rst};

  // Monitor: pops expectations due in this cycle and compares them.
  always @(posedge clk) begin
    ncyc = ncyc + 1;
    #2;
    while (sbq.size() > 0 && sbq[0].cyc == ncyc) begin
      cur = sbq.pop_front();
      nchk = nchk + 1;
      if (obs !== cur.v) begin
        nfail = nfail + 1;
        $display("FAIL %s cycle %0d: got %b expected %b", cur.tag, ncyc, obs, cur.v);
      end
    end
    // R11: the boot core stays powered and coherent whatever the stimulus.
    nchk = nchk + 1;
    if ({c0_iso, c0_logic, c0_pwr, c0_rst} !== 4'b0110) begin
      nfail = nfail + 1;
      $display("FAIL R11 cycle %0d: got %b expected 0110", ncyc, {c0_iso, c0_logic, c0_pwr, c0_rst});
    end
  end

  // Driver: inputs were set at the falling edge; expect v after the next rising edge.
  task automatic tick(input logic [6:0] v, input string tag);
    exp_t e;
    e.cyc = ncyc + 1;
    e.v   = v;
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 5000);
    nfail = nfail + 1;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    tick(V_RUN, "R1");
    tick(V_RUN, "R1");
    rst = 0;
    tick(V_RUN, "R1");

    // R2 standby entry, repeated request ignored
    stby_req = 1; tick(V_STBY, "R2");
    tick(V_STBY, "R2");
    stby_req = 0;
    // R12 external wake ignored in standby
    ext_wake = 1; tick(V_STBY, "R12");
    ext_wake = 0;

    // R4 snoop wakes only the L1 clock
    snoop_req = 1; tick(V_SNP, "R4");
    tick(V_SNP, "R4");
    snoop_req = 0; tick(V_STBY, "R4");

    // R3 interrupt wake, two-cycle exit
    irq_wake = 1; tick(V_EXIT, "R3");
    irq_wake = 0; tick(V_RUN, "R3");

    // R12 external wake ignored while running
    ext_wake = 1; tick(V_RUN, "R12");
    ext_wake = 0;

    // R3 event wake
    stby_req = 1; tick(V_STBY, "R2");
    stby_req = 0; evt_wake = 1; tick(V_EXIT, "R3");
    evt_wake = 0; tick(V_RUN, "R3");

    // R5 dormant request pending without clean flag
    dorm_req = 1; tick(V_RUN, "R5");
    dorm_req = 0; tick(V_RUN, "R5");
    tick(V_RUN, "R5");
    stby_req = 1; tick(V_STBY, "R5");
    stby_req = 0; irq_wake = 1; tick(V_EXIT, "R5");
    irq_wake = 0; tick(V_RUN, "R5");

    // R6 clean flag arms isolation
    clean_done = 1; tick(V_ARM, "R6");
    clean_done = 0; tick(V_ARM, "R6");

    // R7 dormant entry, R9 sleep inputs ignored
    stby_req = 1; tick(V_DORM, "R7");
    irq_wake = 1; evt_wake = 1; snoop_req = 1; tick(V_DORM, "R9");
    stby_req = 0; irq_wake = 0; evt_wake = 0; snoop_req = 0; tick(V_DORM, "R9");

    // R10 external wake, reset held HOLD cycles
    ext_wake = 1; tick(V_RSTH, "R10");
    ext_wake = 0;
    for (int i = 1; i < HOLD; i++) tick(V_RSTH, "R10");
    tick(V_RUN, "R10");
    // R10 old request cleared: plain standby even with clean flag high
    clean_done = 1; stby_req = 1; tick(V_STBY, "R10");
    clean_done = 0; stby_req = 0; irq_wake = 1; tick(V_EXIT, "R3");
    irq_wake = 0; tick(V_RUN, "R3");

    // R8 unplug wins over dormant
    dorm_req = 1; unplug_req = 1; clean_done = 1; tick(V_RUN, "R8");
    dorm_req = 0; unplug_req = 0; tick(V_ARM, "R8");
    clean_done = 0; stby_req = 1; tick(V_OFF, "R8");
    stby_req = 0; irq_wake = 1; tick(V_OFF, "R9");
    irq_wake = 0; tick(V_OFF, "R9");
    ext_wake = 1; tick(V_RSTH, "R10");
    ext_wake = 0;
    for (int i = 1; i < HOLD; i++) tick(V_RSTH, "R10");
    tick(V_RUN, "R10");
    tick(V_RUN, "R10");

    @(negedge clk);
    finish_run();
  end

endmodule